// File: doc/BRIEF.md
# Priority Wildcard Packet Classifier

This block sorts packet header tuples against an ordered table of ternary rules. A tuple is made of a source IPv4 address, a destination IPv4 address, a source port, a destination port and a 12-bit protocol/flags field. The block returns the action code of the lowest-numbered enabled rule that matches the tuple, together with that rule's index. When no rule matches, it raises a no-match flag and returns a default action that the surrounding logic supplies.

Each rule holds a value, a per-bit care mask, a 3-bit action and an enable bit. A write port replaces one table entry at a time, so software can patch the rule set while traffic keeps flowing. Tuples enter through a valid/ready handshake. Classification runs as a two-stage pipeline. The first stage does the parallel compare and a per-group first-match pick. The second stage does the priority pick across groups. The result stage can be held back with `out_ready`.

Top module: `pkt_classifier`

## Requirements
- R1: The 108-bit key is packed as {src_ip[107:76], dst_ip[75:44], src_port[43:28], dst_port[27:12], proto[11:0]}. A rule matches when, for every key bit whose mask bit is 1, the key bit equals the rule value bit. Key bits whose mask bit is 0 are ignored, which allows prefix matches on addresses.
- R2: A rule whose mask is all zeros matches every tuple.
- R3: When several enabled rules match, the result carries the lowest matching index and that rule's action.
- R4: A rule written with its enable bit at 0 never matches, whatever its value and mask.
- R5: When no enabled rule matches, `out_no_match` is 1, `out_index` is 0 and `out_action` equals the default action.
- R6: A write changes only the entry at `wr_idx`. Results for tuples that hit other entries are unchanged.
- R7: A tuple accepted on the same clock edge as a rule write is classified with the table as it was before that write. A tuple accepted on the following edge sees the write.
- R8: With `out_ready` held at 1, `in_ready` stays 1 and one tuple is accepted per cycle. Results leave in acceptance order, and the result of a tuple accepted at edge k is presented after edge k+1.
- R9: While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady. `in_ready` falls only when both pipeline stages are full. No result is lost or duplicated.
- R10: After reset, `out_valid` is 0, `in_ready` is 1 and every rule is disabled.
- R11: The default action used for a no-match result is the value of `default_action` at the edge where that tuple was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Tuple present |
| in_ready | output | 1 | Tuple accepted when in_valid is also 1 |
| in_src_ip | input | 32 | Source IPv4 address |
| in_dst_ip | input | 32 | Destination IPv4 address |
| in_src_port | input | 16 | Source port |
| in_dst_port | input | 16 | Destination port |
| in_proto | input | 12 | Protocol/flags field |
| default_action | input | 3 | Action returned when nothing matches |
| wr_en | input | 1 | Rule write strobe |
| wr_idx | input | 6 | Entry being replaced |
| wr_rule_valid | input | 1 | Enable bit of the new entry |
| wr_value | input | 108 | Match value, packed as in R1 |
| wr_mask | input | 108 | Care mask, 1 = bit compared |
| wr_action | input | 3 | Action of the new entry |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed when out_valid is also 1 |
| out_action | output | 3 | Action of the winning rule or the default |
| out_index | output | 6 | Index of the winning rule, 0 on no match |
| out_no_match | output | 1 | No enabled rule matched |

## Verification
A rule write and a tuple acceptance can land on the same clock edge. In that case the tuple must see the old table, and the tuple accepted on the next edge must see the new entry. The bench provokes this by driving the write and the tuple in one cycle and then repeating the same tuple in the next cycle. Its reference model computes each expected result from the rule image held just before that cycle's write is applied. A second coincidence is a stall at the output while a new tuple is offered. Here the bench checks that the held result does not move, that `in_ready` drops only with both stages full, and that all three results later come out in order.

// File: rtl/pkt_cls_pkg.sv
package pkt_cls_pkg;

    localparam int SRC_IP_W = 32;
    localparam int DST_IP_W = 32;
    localparam int PORT_W   = 16;
    localparam int PROTO_W  = 12;
    localparam int KEY_W    = SRC_IP_W + DST_IP_W + 2 * PORT_W + PROTO_W;

    typedef logic [KEY_W-1:0] key_t;

    function automatic key_t pack_key(
        input logic [SRC_IP_W-1:0] src_ip,
        input logic [DST_IP_W-1:0] dst_ip,
        input logic [PORT_W-1:0]   src_port,
        input logic [PORT_W-1:0]   dst_port,
        input logic [PROTO_W-1:0]  proto
    );
        return {src_ip, dst_ip, src_port, dst_port, proto};
    endfunction

endpackage

// File: rtl/pkt_cls_table.sv
module pkt_cls_table #(
    parameter int NUM_RULES = 64,
    parameter int KEY_W     = 108,
    parameter int ACT_W     = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [$clog2(NUM_RULES)-1:0]        wr_idx,
    input  logic                                wr_rule_valid,
    input  logic [KEY_W-1:0]                    wr_value,
    input  logic [KEY_W-1:0]                    wr_mask,
    input  logic [ACT_W-1:0]                    wr_action,
    output logic [NUM_RULES-1:0]                rule_vld,
    output logic [NUM_RULES-1:0][KEY_W-1:0]     rule_val,
    output logic [NUM_RULES-1:0][KEY_W-1:0]     rule_msk,
    output logic [NUM_RULES-1:0][ACT_W-1:0]     rule_act
);

    typedef struct packed {
        logic [NUM_RULES-1:0]            vld;
        logic [NUM_RULES-1:0][KEY_W-1:0] val;
        logic [NUM_RULES-1:0][KEY_W-1:0] msk;
        logic [NUM_RULES-1:0][ACT_W-1:0] act;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.vld[wr_idx] = wr_rule_valid;
            // value kept pre-masked so the compare needs no extra gate
            tbl_d.val[wr_idx] = wr_value & wr_mask;
            tbl_d.msk[wr_idx] = wr_mask;
            tbl_d.act[wr_idx] = wr_action;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rule_vld = tbl_q.vld;
    assign rule_val = tbl_q.val;
    assign rule_msk = tbl_q.msk;
    assign rule_act = tbl_q.act;

endmodule

// File: rtl/pkt_cls_match.sv
module pkt_cls_match #(
    parameter int NUM_RULES = 64,
    parameter int KEY_W     = 108
) (
    input  logic [KEY_W-1:0]                key,
    input  logic [NUM_RULES-1:0]            rule_vld,
    input  logic [NUM_RULES-1:0][KEY_W-1:0] rule_val,
    input  logic [NUM_RULES-1:0][KEY_W-1:0] rule_msk,
    output logic [NUM_RULES-1:0]            hit
);

    for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
        assign hit[r] = rule_vld[r] && ((key & rule_msk[r]) == rule_val[r]);
    end

endmodule

// File: rtl/pkt_cls_group_enc.sv
module pkt_cls_group_enc #(
    parameter int NUM_RULES  = 64,
    parameter int GROUP_SIZE = 8,
    parameter int ACT_W      = 3,
    localparam int NUM_GROUPS = NUM_RULES / GROUP_SIZE,
    localparam int LOC_W      = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1
) (
    input  logic [NUM_RULES-1:0]             hit,
    input  logic [NUM_RULES-1:0][ACT_W-1:0]  rule_act,
    output logic [NUM_GROUPS-1:0]            grp_hit,
    output logic [NUM_GROUPS-1:0][LOC_W-1:0] grp_loc,
    output logic [NUM_GROUPS-1:0][ACT_W-1:0] grp_act
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic             h;
        logic [LOC_W-1:0] l;
        logic [ACT_W-1:0] a;

        // scan downward so the lowest set position is the last one written
        always_comb begin
            h = 1'b0;
            l = '0;
            a = '0;
            for (int j = GROUP_SIZE - 1; j >= 0; j--) begin
                if (hit[g * GROUP_SIZE + j]) begin
                    h = 1'b1;
                    l = LOC_W'(j);
                    a = rule_act[g * GROUP_SIZE + j];
                end
            end
        end

        assign grp_hit[g] = h;
        assign grp_loc[g] = l;
        assign grp_act[g] = a;
    end

endmodule

// File: rtl/pkt_cls_final_enc.sv
module pkt_cls_final_enc #(
    parameter int NUM_RULES  = 64,
    parameter int GROUP_SIZE = 8,
    parameter int ACT_W      = 3,
    localparam int NUM_GROUPS = NUM_RULES / GROUP_SIZE,
    localparam int LOC_W      = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1,
    localparam int IDX_W      = $clog2(NUM_RULES)
) (
    input  logic [NUM_GROUPS-1:0]            grp_hit,
    input  logic [NUM_GROUPS-1:0][LOC_W-1:0] grp_loc,
    input  logic [NUM_GROUPS-1:0][ACT_W-1:0] grp_act,
    input  logic [ACT_W-1:0]                 dflt_act,
    output logic                             any_hit,
    output logic [IDX_W-1:0]                 win_idx,
    output logic [ACT_W-1:0]                 win_act
);

    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        win_act = dflt_act;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (grp_hit[g]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(g * GROUP_SIZE) + IDX_W'(grp_loc[g]);
                win_act = grp_act[g];
            end
        end
    end

endmodule

// File: rtl/pkt_classifier.sv
module pkt_classifier
    import pkt_cls_pkg::*;
#(
    parameter int NUM_RULES  = 64,
    parameter int GROUP_SIZE = 8,
    parameter int ACT_W      = 3,
    localparam int IDX_W      = $clog2(NUM_RULES),
    localparam int NUM_GROUPS = NUM_RULES / GROUP_SIZE,
    localparam int LOC_W      = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SRC_IP_W-1:0] in_src_ip,
    input  logic [DST_IP_W-1:0] in_dst_ip,
    input  logic [PORT_W-1:0]   in_src_port,
    input  logic [PORT_W-1:0]   in_dst_port,
    input  logic [PROTO_W-1:0]  in_proto,
    input  logic [ACT_W-1:0]    default_action,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_rule_valid,
    input  logic [KEY_W-1:0]    wr_value,
    input  logic [KEY_W-1:0]    wr_mask,
    input  logic [ACT_W-1:0]    wr_action,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ACT_W-1:0]    out_action,
    output logic [IDX_W-1:0]    out_index,
    output logic                out_no_match
);

    typedef struct packed {
        logic                             valid;
        logic [NUM_GROUPS-1:0]            grp_hit;
        logic [NUM_GROUPS-1:0][LOC_W-1:0] grp_loc;
        logic [NUM_GROUPS-1:0][ACT_W-1:0] grp_act;
        logic [ACT_W-1:0]                 dflt;
    } cmp_stage_t;

    typedef struct packed {
        logic             valid;
        logic [ACT_W-1:0] action;
        logic [IDX_W-1:0] index;
        logic             no_match;
    } res_stage_t;

    typedef struct packed {
        cmp_stage_t cmp;
        res_stage_t res;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    // rule storage
    logic [NUM_RULES-1:0]            rule_vld;
    logic [NUM_RULES-1:0][KEY_W-1:0] rule_val;
    logic [NUM_RULES-1:0][KEY_W-1:0] rule_msk;
    logic [NUM_RULES-1:0][ACT_W-1:0] rule_act;

    pkt_cls_table #(
        .NUM_RULES (NUM_RULES),
        .KEY_W     (KEY_W),
        .ACT_W     (ACT_W)
    ) table_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_rule_valid (wr_rule_valid),
        .wr_value      (wr_value),
        .wr_mask       (wr_mask),
        .wr_action     (wr_action),
        .rule_vld      (rule_vld),
        .rule_val      (rule_val),
        .rule_msk      (rule_msk),
        .rule_act      (rule_act)
    );

    // stage 1: parallel compare and in-group pick
    key_t                  in_key;
    logic [NUM_RULES-1:0]  hit;

    assign in_key = pack_key(in_src_ip, in_dst_ip, in_src_port, in_dst_port, in_proto);

    pkt_cls_match #(
        .NUM_RULES (NUM_RULES),
        .KEY_W     (KEY_W)
    ) match_i (
        .key      (in_key),
        .rule_vld (rule_vld),
        .rule_val (rule_val),
        .rule_msk (rule_msk),
        .hit      (hit)
    );

    logic [NUM_GROUPS-1:0]            grp_hit;
    logic [NUM_GROUPS-1:0][LOC_W-1:0] grp_loc;
    logic [NUM_GROUPS-1:0][ACT_W-1:0] grp_act;

    pkt_cls_group_enc #(
        .NUM_RULES  (NUM_RULES),
        .GROUP_SIZE (GROUP_SIZE),
        .ACT_W      (ACT_W)
    ) grp_enc_i (
        .hit      (hit),
        .rule_act (rule_act),
        .grp_hit  (grp_hit),
        .grp_loc  (grp_loc),
        .grp_act  (grp_act)
    );

    // stage 2: pick across groups from registered group results
    logic             fin_hit;
    logic [IDX_W-1:0] fin_idx;
    logic [ACT_W-1:0] fin_act;

    pkt_cls_final_enc #(
        .NUM_RULES  (NUM_RULES),
        .GROUP_SIZE (GROUP_SIZE),
        .ACT_W      (ACT_W)
    ) fin_enc_i (
        .grp_hit  (pipe_q.cmp.grp_hit),
        .grp_loc  (pipe_q.cmp.grp_loc),
        .grp_act  (pipe_q.cmp.grp_act),
        .dflt_act (pipe_q.cmp.dflt),
        .any_hit  (fin_hit),
        .win_idx  (fin_idx),
        .win_act  (fin_act)
    );

    logic res_adv;
    logic cmp_adv;

    always_comb begin
        pipe_d  = pipe_q;
        res_adv = !pipe_q.res.valid || out_ready;
        cmp_adv = !pipe_q.cmp.valid || res_adv;

        if (res_adv) begin
            pipe_d.res.valid    = pipe_q.cmp.valid;
            pipe_d.res.action   = fin_act;
            pipe_d.res.index    = fin_idx;
            pipe_d.res.no_match = !fin_hit;
        end

        if (cmp_adv) begin
            pipe_d.cmp.valid   = in_valid;
            pipe_d.cmp.grp_hit = grp_hit;
            pipe_d.cmp.grp_loc = grp_loc;
            pipe_d.cmp.grp_act = grp_act;
            pipe_d.cmp.dflt    = default_action;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign in_ready     = cmp_adv;
    assign out_valid    = pipe_q.res.valid;
    assign out_action   = pipe_q.res.action;
    assign out_index    = pipe_q.res.index;
    assign out_no_match = pipe_q.res.no_match;

endmodule

// File: rtl/pkt_classifier_chk.sv
module pkt_classifier_chk #(
    parameter int NUM_RULES = 64,
    parameter int ACT_W     = 3,
    localparam int IDX_W    = $clog2(NUM_RULES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [ACT_W-1:0]     out_action,
    input logic [IDX_W-1:0]     out_index,
    input logic                 out_no_match,
    input logic                 wr_en,
    input logic [IDX_W-1:0]     wr_idx,
    input logic                 wr_rule_valid,
    input logic [NUM_RULES-1:0] rule_vld_vec
);

    // R9: a stalled result stays put
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_action)
                                       && $stable(out_index) && $stable(out_no_match)));

    // R9: input side blocks only when the output side is stalled
    a_r9_ready_only_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));

    // R5: a no-match result reports index zero
    a_r5_nomatch_index: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_no_match) |-> (out_index == '0));

    // R6: a write lands in the addressed entry on the next cycle
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rule_vld_vec[$past(wr_idx)] == $past(wr_rule_valid)));

    // R4: with every entry disabled nothing can report a match
    a_r4_empty_table: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rule_vld_vec == '0) && $past(rule_vld_vec == '0, 2)
         && $past(rst_n, 2)) |-> out_no_match);

endmodule

bind pkt_classifier pkt_classifier_chk #(
    .NUM_RULES (NUM_RULES),
    .ACT_W     (ACT_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_action    (out_action),
    .out_index     (out_index),
    .out_no_match  (out_no_match),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_rule_valid (wr_rule_valid),
    .rule_vld_vec  (rule_vld)
);

// File: tb/pkt_classifier_tb_top.sv
module pkt_classifier_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [107:0] tkey;
    logic [2:0]   default_action;
    logic         wr_en;
    logic [5:0]   wr_idx;
    logic         wr_rule_valid;
    logic [107:0] wr_value;
    logic [107:0] wr_mask;
    logic [2:0]   wr_action;
    logic         out_valid;
    logic         out_ready;
    logic [2:0]   out_action;
    logic [5:0]   out_index;
    logic         out_no_match;

    pkt_classifier dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_src_ip      (tkey[107:76]),
        .in_dst_ip      (tkey[75:44]),
        .in_src_port    (tkey[43:28]),
        .in_dst_port    (tkey[27:12]),
        .in_proto       (tkey[11:0]),
        .default_action (default_action),
        .wr_en          (wr_en),
        .wr_idx         (wr_idx),
        .wr_rule_valid  (wr_rule_valid),
        .wr_value       (wr_value),
        .wr_mask        (wr_mask),
        .wr_action      (wr_action),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_action     (out_action),
        .out_index      (out_index),
        .out_no_match   (out_no_match)
    );

    int checks = 0;
    int fails  = 0;

    // reference rule image
    logic [107:0] m_val [64];
    logic [107:0] m_msk [64];
    logic [2:0]   m_act [64];
    logic         m_vld [64];

    logic [9:0] exp_q [$];
    string      tag_q [$];
    string      cur_tag = "R10";

    function automatic logic [107:0] mk(input logic [31:0] s, input logic [31:0] d,
                                        input logic [15:0] sp, input logic [15:0] dp,
                                        input logic [11:0] pr);
        return {s, d, sp, dp, pr};
    endfunction

    function automatic logic [9:0] model(input logic [107:0] k, input logic [2:0] dflt);
        for (int i = 0; i < 64; i++) begin
            if (m_vld[i] && ((k & m_msk[i]) == (m_val[i] & m_msk[i])))
                return {1'b0, 6'(i), m_act[i]};
        end
        return {1'b1, 6'd0, dflt};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    // result monitor, sampled between edges
    always @(negedge clk) begin : mon
        logic [9:0] e;
        string      t;
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 result without tuple", {22'd0, out_no_match, out_index, out_action}, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({out_no_match, out_index, out_action} == e, t,
                        {22'd0, out_no_match, out_index, out_action}, {22'd0, e});
                end
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(model(tkey, default_action));
                tag_q.push_back(cur_tag);
            end
            if (wr_en) begin
                m_vld[wr_idx] = wr_rule_valid;
                m_val[wr_idx] = wr_value;
                m_msk[wr_idx] = wr_mask;
                m_act[wr_idx] = wr_action;
            end
        end
    end

    // one cycle of stimulus; entered and left at posedge + 2
    task automatic step(input bit do_t, input logic [107:0] k, input bit do_w,
                        input logic [5:0] idx, input bit vld, input logic [107:0] val,
                        input logic [107:0] msk, input logic [2:0] act);
        in_valid      = do_t;
        tkey          = k;
        wr_en         = do_w;
        wr_idx        = idx;
        wr_rule_valid = vld;
        wr_value      = val;
        wr_mask       = msk;
        wr_action     = act;
        @(posedge clk);
        #2;
        in_valid = 1'b0;
        wr_en    = 1'b0;
    endtask

    task automatic send(input logic [107:0] k);
        step(1'b1, k, 1'b0, 6'd0, 1'b0, '0, '0, 3'd0);
    endtask

    task automatic wr(input logic [5:0] idx, input bit vld, input logic [107:0] val,
                      input logic [107:0] msk, input logic [2:0] act);
        step(1'b0, '0, 1'b1, idx, vld, val, msk, act);
    endtask

    task automatic drain();
        repeat (4) @(posedge clk);
        #2;
        chk(exp_q.size() == 0, {cur_tag, " drained"}, exp_q.size(), 0);
    endtask

    localparam logic [107:0] ALL  = {108{1'b1}};
    localparam logic [107:0] NONE = '0;

    logic [107:0] k1, k2, k3, k4;

    task automatic t_reset();
        cur_tag = "R10";
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
        @(posedge clk);
        #2;
        send(k1);
        send(k2);
        drain();
    endtask

    task automatic t_ternary();
        cur_tag = "R1";
        // src 10.1.2.0/24 and dst port 80, rest ignored
        wr(6'd10, 1'b1, mk(32'h0A010200, 0, 0, 16'd80, 0),
           mk(32'hFFFFFF00, 0, 0, 16'hFFFF, 0), 3'd1);
        send(k1);
        send(k2);
        send(k3);
        drain();
    endtask

    task automatic t_wild_prio();
        cur_tag = "R2";
        wr(6'd63, 1'b1, mk(32'hDEADBEEF, 32'h12345678, 16'd7, 16'd9, 12'hABC), NONE, 3'd7);
        send(k2);
        send(k4);
        cur_tag = "R3";
        send(k1);
        wr(6'd3, 1'b1, mk(0, 0, 0, 0, 12'h006), mk(0, 0, 0, 0, 12'hFFF), 3'd4);
        send(k1);
        send(mk(32'h0A010277, 32'h01020304, 16'd1, 16'd80, 12'h011));
        drain();
    endtask

    task automatic t_invalid();
        cur_tag = "R4";
        wr(6'd3, 1'b0, mk(0, 0, 0, 0, 12'h006), mk(0, 0, 0, 0, 12'hFFF), 3'd4);
        send(k1);
        wr(6'd63, 1'b0, NONE, NONE, 3'd7);
        send(k2);
        send(k4);
        drain();
    endtask

    task automatic t_replace();
        cur_tag = "R6";
        wr(6'd20, 1'b1, mk(0, 32'hC0A80000, 0, 0, 0), mk(0, 32'hFFFF0000, 0, 0, 0), 3'd2);
        send(k2);
        wr(6'd40, 1'b1, mk(0, 0, 0, 16'd22, 0), mk(0, 0, 0, 16'hFFFF, 0), 3'd3);
        send(k2);
        wr(6'd10, 1'b1, mk(32'h0A010200, 0, 0, 16'd443, 0),
           mk(32'hFFFFFF00, 0, 0, 16'hFFFF, 0), 3'd1);
        send(k1);
        send(mk(32'h0A010201, 32'h08080808, 16'd5, 16'd443, 12'h006));
        drain();
    endtask

    task automatic t_write_timing();
        cur_tag = "R7";
        // tuple and write in the same cycle: old table applies
        step(1'b1, k3, 1'b1, 6'd0, 1'b1, NONE, NONE, 3'd6);
        send(k3);
        step(1'b1, k3, 1'b1, 6'd0, 1'b0, NONE, NONE, 3'd6);
        send(k3);
        drain();
    endtask

    task automatic t_stream();
        cur_tag = "R8";
        send(k1);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 result not before second edge", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R8 result after second edge", out_valid, 1);
        @(posedge clk);
        #2;
        for (int i = 0; i < 10; i++) begin
            chk(in_ready == 1'b1, "R8 in_ready while streaming", in_ready, 1);
            send(mk(32'h0A010200 + 32'(i * 37), 32'hC0A80000 + 32'(i), 16'(i),
                    (i % 3 == 0) ? 16'd443 : 16'd22, 12'(i)));
        end
        drain();
    endtask

    task automatic t_backpressure();
        logic [9:0] held;
        cur_tag = "R9";
        out_ready = 1'b0;
        send(k1);
        send(k2);
        in_valid = 1'b1;
        tkey     = k4;
        #1;
        chk(in_ready == 1'b0, "R9 in_ready low with both stages full", in_ready, 0);
        held = {out_no_match, out_index, out_action};
        repeat (3) @(posedge clk);
        #2;
        chk(out_valid == 1'b1, "R9 out_valid held", out_valid, 1);
        chk({out_no_match, out_index, out_action} == held, "R9 output stable",
            {22'd0, out_no_match, out_index, out_action}, {22'd0, held});
        chk(in_ready == 1'b0, "R9 in_ready still low", in_ready, 0);
        out_ready = 1'b1;
        @(posedge clk);
        #2;
        in_valid = 1'b0;
        drain();
    endtask

    task automatic t_default();
        cur_tag = "R11";
        default_action = 3'd5;
        send(k4);
        default_action = 3'd2;
        send(k4);
        default_action = 3'd0;
        send(k4);
        cur_tag = "R5";
        send(mk(32'h01010101, 32'h02020202, 16'd1, 16'd2, 12'h001));
        drain();
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_val[i] = '0;
            m_msk[i] = '0;
            m_act[i] = '0;
            m_vld[i] = 1'b0;
        end
        rst_n          = 1'b0;
        in_valid       = 1'b0;
        tkey           = '0;
        default_action = 3'd0;
        wr_en          = 1'b0;
        wr_idx         = '0;
        wr_rule_valid  = 1'b0;
        wr_value       = '0;
        wr_mask        = '0;
        wr_action      = '0;
        out_ready      = 1'b1;
        k1 = mk(32'h0A01024D, 32'hC0A80001, 16'd5000, 16'd80, 12'h006);
        k2 = mk(32'h0A01034D, 32'hC0A80001, 16'd5000, 16'd80, 12'h006);
        k3 = mk(32'h0A01024D, 32'hC0A80001, 16'd5000, 16'd81, 12'h006);
        k4 = mk(32'h08080808, 32'h09090909, 16'd1234, 16'd53, 12'h011);
        repeat (2) @(posedge clk);
        t_reset();
        t_ternary();
        t_wild_prio();
        t_invalid();
        t_replace();
        t_write_timing();
        t_stream();
        t_backpressure();
        t_default();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule